// File: doc/BRIEF.md
# Lockable Battery-Backed CMOS RAM

This block is the byte store that sits beside a real-time-clock unit and keeps its contents while the rest of the chip is off. Software reaches it through an index/data pair. It first loads a byte address with an index write. It then moves a byte in or out with a data write or a data read strobe. Read data is registered and appears one cycle after the read strobe.

Two 8-byte windows can each be protected. Each window starts at an 8-byte aligned block number given on an input. A lock bit per window is set through a small configuration port. A locked window drops writes and returns 8'hFF on reads. Lock bits are set-only: only the hard reset clears them.

A second reset belongs to the battery well. It raises a power-status flag and puts a battery-well configuration byte back to its default. It does not touch the byte array, the lock bits or the index. The hard reset, in turn, leaves the battery-well state and the array alone.

Top module: `cmos_lock_ram`

## Requirements
- R1: While `hard_rst_n` is low, and after it is released, the index, both lock bits and `rdata` are 0.
- R2: A data write stores `wdata` at the current index. A data read puts the stored byte on `rdata` after the next clock edge. `rdata` holds its value in cycles without a read strobe.
- R3: A configuration write to address 0 ORs `cfg_wdata[0]` into the lock of window 0 and `cfg_wdata[1]` into the lock of window 1. Window k covers byte addresses `wink_base*8` to `wink_base*8+7`. Reading address 0 returns the lock bits in bits 1:0, with zeros above.
- R4: A data write to a byte inside a locked window leaves that byte unchanged. This is seen by reading it after a hard reset has released the lock.
- R5: A data read of a byte inside a locked window returns 8'hFF.
- R6: Writing zeros to the lock register leaves the locks set. The battery-well reset does not clear them. Only `hard_rst_n` low clears them.
- R7: Bytes outside every locked window are read and written normally while a lock is set.
- R8: A data access in the same cycle as the configuration write that sets a lock is judged against the lock state before that write, so the access still reaches the array.
- R9: `well_rst_n` low sets the power flag (configuration address 1, bit 0). It also returns the battery-well byte (configuration address 2) to 8'hA5. It leaves the array contents and the lock bits as they were.
- R10: Writing 1 to bit 0 of configuration address 1 clears the power flag, and writing 0 leaves it. While `well_rst_n` is still low, the flag stays set. A hard reset changes neither the flag nor the battery-well byte.
- R11: A configuration write to address 2 stores the battery-well byte, which reads back on `cfg_rdata` in the same cycle its address is selected. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset, active low, asynchronous |
| well_rst_n | input | 1 | Battery-well reset, active low, asynchronous |
| idx_we | input | 1 | Load the index from `wdata` |
| dat_we | input | 1 | Write `wdata` at the index |
| dat_re | input | 1 | Read the byte at the index into `rdata` |
| wdata | input | 8 | Index or data byte |
| rdata | output | 8 | Registered read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register |
| win0_base | input | 4 | 8-byte block number of window 0 |
| win1_base | input | 4 | 8-byte block number of window 1 |

## Verification
Some functions can meet in the same clock. The bench provokes these collisions on purpose and judges each one against a behavioural model that is updated on every edge. One collision is the configuration write that sets a lock, issued together with a data write into that window. The write must land, and the byte is read back after a later hard reset. A second is a flag-clear write issued while the battery-well reset is still held. The flag must stay set there, and it must clear after release. A third is a battery-well reset issued while both locks are set. It must restore the default byte and keep the windows locked.

// File: rtl/cmos_lock_ram.sv
module cmos_lock_ram #(
  parameter int DEPTH      = 128,
  parameter int WIN_BYTES  = 8,
  parameter logic [7:0] FILL     = 8'hFF,
  parameter logic [7:0] WELL_DEF = 8'hA5,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = $clog2(WIN_BYTES),
  localparam int BW = AW - WW
) (
  input  logic          clk,
  input  logic          hard_rst_n,
  input  logic          well_rst_n,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic          dat_re,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [BW-1:0] win0_base,
  input  logic [BW-1:0] win1_base
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx;
  logic [1:0]    lock;
  logic          pwr_flag;
  logic [7:0]    well_cfg;

  wire hit0    = lock[0] && (idx[AW-1:WW] == win0_base);
  wire hit1    = lock[1] && (idx[AW-1:WW] == win1_base);
  wire blocked = hit0 || hit1;

  always_ff @(posedge clk)
    if (dat_we && !blocked) mem[idx] <= wdata;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      idx   <= '0;
      lock  <= '0;
      rdata <= '0;
    end else begin
      if (dat_re) rdata <= blocked ? FILL : mem[idx];
      if (idx_we) idx <= wdata[AW-1:0];
      if (cfg_we && cfg_addr == 2'd0) lock <= lock | cfg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge well_rst_n) begin
    if (!well_rst_n) begin
      pwr_flag <= 1'b1;
      well_cfg <= WELL_DEF;
    end else begin
      if (cfg_we && cfg_addr == 2'd1 && cfg_wdata[0]) pwr_flag <= 1'b0;
      if (cfg_we && cfg_addr == 2'd2) well_cfg <= cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {6'd0, lock};
      2'd1:    cfg_rdata = {7'd0, pwr_flag};
      2'd2:    cfg_rdata = well_cfg;
      default: cfg_rdata = 8'd0;
    endcase
  end

endmodule

// File: rtl/cmos_lock_ram_chk.sv
module cmos_lock_ram_chk #(
  parameter int DEPTH = 128,
  parameter int WIN_BYTES = 8,
  parameter logic [7:0] FILL = 8'hFF,
  parameter logic [7:0] WELL_DEF = 8'hA5,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = $clog2(WIN_BYTES),
  localparam int BW = AW - WW
) (
  input logic          clk,
  input logic          hard_rst_n,
  input logic          well_rst_n,
  input logic          dat_we,
  input logic          dat_re,
  input logic [AW-1:0] idx,
  input logic [1:0]    lock,
  input logic [BW-1:0] win0_base,
  input logic [BW-1:0] win1_base,
  input logic [7:0]    rdata,
  input logic [7:0]    mem [DEPTH],
  input logic          pwr_flag,
  input logic [7:0]    well_cfg
);

  logic in_win;
  assign in_win = (lock[0] && idx[AW-1:WW] == win0_base) ||
                  (lock[1] && idx[AW-1:WW] == win1_base);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
    lock != 2'b00 |=> (lock & $past(lock)) == $past(lock));

  p_locked_read_fill_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
    dat_re && in_win |=> rdata == FILL);

  p_locked_write_kept_r4: assert property (@(posedge clk) disable iff (!hard_rst_n)
    dat_we && in_win |=> mem[$past(idx)] == $past(mem[idx]));

  p_read_hold_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !dat_re |=> $stable(rdata));

  p_flag_held_r9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !well_rst_n |-> pwr_flag);

  p_well_default_r9: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(well_rst_n) |-> well_cfg == WELL_DEF);

endmodule

bind cmos_lock_ram cmos_lock_ram_chk #(
  .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES), .FILL(FILL), .WELL_DEF(WELL_DEF)
) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .well_rst_n(well_rst_n),
  .dat_we(dat_we), .dat_re(dat_re), .idx(idx), .lock(lock),
  .win0_base(win0_base), .win1_base(win1_base), .rdata(rdata),
  .mem(mem), .pwr_flag(pwr_flag), .well_cfg(well_cfg)
);

// File: tb/tb_cmos_lock_ram.sv
module tb_cmos_lock_ram;
  logic clk = 1'b0;
  logic hard_rst_n = 1'b0, well_rst_n = 1'b0;
  logic idx_we = 0, dat_we = 0, dat_re = 0, cfg_we = 0;
  logic [7:0] wdata = 0, cfg_wdata = 0;
  logic [1:0] cfg_addr = 0;
  logic [3:0] win0_base = 4'd2, win1_base = 4'd9;
  logic [7:0] rdata, cfg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R1";

  always #10 clk = ~clk;

  cmos_lock_ram dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .well_rst_n(well_rst_n),
    .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re), .wdata(wdata),
    .rdata(rdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .win0_base(win0_base), .win1_base(win1_base));

  // behavioural reference
  logic [7:0] m_mem [128];
  int   m_idx = 0;
  logic [1:0] m_lock = 0;
  logic m_flag = 1;
  logic [7:0] m_cfg = 8'hA5, m_rd = 0;

  function automatic bit m_locked(int a);
    return (m_lock[0] && (a / 8) == int'(win0_base)) ||
           (m_lock[1] && (a / 8) == int'(win1_base));
  endfunction

  function automatic logic [7:0] m_cfg_rd();
    case (cfg_addr)
      2'd0: return {6'd0, m_lock};
      2'd1: return {7'd0, m_flag};
      2'd2: return m_cfg;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    bit blk;
    blk = m_locked(m_idx);
    if (dat_we && !blk) m_mem[m_idx] = wdata;
    if (hard_rst_n) begin
      if (dat_re) m_rd = blk ? 8'hFF : m_mem[m_idx];
      if (idx_we) m_idx = int'(wdata[6:0]);
      if (cfg_we && cfg_addr == 2'd0) m_lock = m_lock | cfg_wdata[1:0];
    end
    if (well_rst_n) begin
      if (cfg_we && cfg_addr == 2'd1 && cfg_wdata[0]) m_flag = 0;
      if (cfg_we && cfg_addr == 2'd2) m_cfg = cfg_wdata;
    end
    if (!hard_rst_n) begin m_idx = 0; m_lock = 0; m_rd = 0; end
    if (!well_rst_n) begin m_flag = 1; m_cfg = 8'hA5; end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
    chk(rdata, m_rd, {cur, " model rdata"});
    chk(cfg_rdata, m_cfg_rd(), {cur, " model cfg_rdata"});
  endtask

  task automatic set_idx(input int a);
    idx_we = 1; wdata = 8'(a); tick(); idx_we = 0;
  endtask

  task automatic put(input int a, input logic [7:0] d);
    set_idx(a); dat_we = 1; wdata = d; tick(); dat_we = 0;
  endtask

  task automatic get(input int a, output logic [7:0] d);
    set_idx(a); dat_re = 1; tick(); dat_re = 0; d = rdata;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    cur = "R1";
    chk(rdata, 8'h00, "R1 rdata in reset");
    peek(2'd0, v); chk(v, 8'h00, "R1 locks in reset");
    hard_rst_n = 1; well_rst_n = 1;
    tick();
    chk(rdata, 8'h00, "R1 rdata after release");

    cur = "R2";
    for (int a = 0; a < 128; a++) put(a, pat(a));
    get(5, v);  chk(v, pat(5), "R2 read back 0x05");
    get(127, v); chk(v, pat(127), "R2 read back 0x7F");
    tick(); tick(); chk(rdata, pat(127), "R2 rdata held");

    cur = "R3";
    cfg(2'd0, 8'h01);
    peek(2'd0, v); chk(v, 8'h01, "R3 lock0 set");
    cur = "R5";
    get(8'h10, v); chk(v, 8'hFF, "R5 locked low edge");
    get(8'h17, v); chk(v, 8'hFF, "R5 locked high edge");
    cur = "R7";
    get(8'h18, v); chk(v, pat(8'h18), "R7 byte above window");
    get(8'h0F, v); chk(v, pat(8'h0F), "R7 byte below window");
    put(8'h0F, 8'hC3); get(8'h0F, v); chk(v, 8'hC3, "R7 write outside window");

    cur = "R4";
    put(8'h12, 8'h00);
    get(8'h12, v); chk(v, 8'hFF, "R4 locked still filled");

    cur = "R6";
    cfg(2'd0, 8'h00);
    peek(2'd0, v); chk(v, 8'h01, "R6 zero write keeps lock");

    cur = "R8";
    set_idx(8'h48);
    cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 8'h02;
    dat_we = 1; wdata = 8'h77;
    tick(); cfg_we = 0; dat_we = 0;
    dat_re = 1; tick(); dat_re = 0;
    chk(rdata, 8'hFF, "R8 lock active next cycle");

    cur = "R11";
    cfg(2'd2, 8'h3C);
    peek(2'd2, v); chk(v, 8'h3C, "R11 well byte stored");
    peek(2'd3, v); chk(v, 8'h00, "R11 address 3 zero");
    cur = "R10";
    cfg(2'd1, 8'h00);
    peek(2'd1, v); chk(v, 8'h01, "R10 zero write keeps flag");
    cfg(2'd1, 8'h01);
    peek(2'd1, v); chk(v, 8'h00, "R10 flag cleared");

    cur = "R9";
    well_rst_n = 0; tick();
    peek(2'd1, v); chk(v, 8'h01, "R9 flag raised");
    peek(2'd2, v); chk(v, 8'hA5, "R9 well byte default");
    peek(2'd0, v); chk(v, 8'h03, "R9 R6 locks survive well reset");
    cur = "R10";
    cfg(2'd1, 8'h01);
    peek(2'd1, v); chk(v, 8'h01, "R10 clear ignored during well reset");
    well_rst_n = 1; tick();
    cur = "R9";
    get(8'h11, v); chk(v, 8'hFF, "R9 window still locked");
    get(8'h20, v); chk(v, pat(8'h20), "R9 array kept");

    cur = "R10";
    cfg(2'd2, 8'h66);
    hard_rst_n = 0; tick(); tick();
    hard_rst_n = 1; tick();
    peek(2'd1, v); chk(v, 8'h01, "R10 flag survives hard reset");
    peek(2'd2, v); chk(v, 8'h66, "R10 well byte survives hard reset");
    cur = "R6";
    peek(2'd0, v); chk(v, 8'h00, "R6 hard reset unlocks");
    cur = "R4";
    get(8'h12, v); chk(v, pat(8'h12), "R4 locked write dropped");
    cur = "R8";
    get(8'h48, v); chk(v, 8'h77, "R8 same-cycle write landed");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got %h exp %h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule